// File: doc/BRIEF.md
# UART Transmit Queue with Flow Control

This block sits between the register interface of a UART and its transmit serialiser. Software writes characters through a push port. Each character is stored together with the framing that line control selects when it is written: two stop bits, parity enable and even parity. The entries wait in an eight-deep queue. They are handed one at a time to the serialiser over a valid/ready load handshake. Hand-over is gated by a transmit-halt control and, when CTS gating is switched on, by the level of the CTS input.

The block also drives the RTS pin. Software can force RTS off. Otherwise RTS drops when the receive fill level reaches a programmable threshold. A break control forces the serial output to the space level. Status outputs report the queue level, a sticky push-overflow flag, a threshold-based transmit interrupt status, the CTS line state, and an "all sent" flag that covers both the queue and the serialiser.

A small sequencer with three states decides when an offer is made:
- `ST_IDLE`: the queue is empty.
- `ST_OFFER`: the head entry is presented on the load port.
- `ST_HELD`: data is waiting but the gate is closed.

It uses these transitions:
- `ST_IDLE` to `ST_OFFER` when data is present and the gate is open.
- `ST_IDLE` to `ST_HELD` when data is present and the gate is closed.
- `ST_OFFER` to `ST_HELD` when the gate closes before a load.
- `ST_OFFER` to `ST_IDLE` when the last entry is loaded and no push arrives in the same cycle.
- `ST_HELD` to `ST_OFFER` when the gate reopens.

Top module: `uart_txq_flow`

## Requirements
- R1: Characters reach the load port in the order they were pushed, and `fifo_level` equals the number of stored entries, at most 8. A load (`ld_valid` and `ld_ready` high at a clock edge) removes the head entry.
- R2: A push while the level is 8 is dropped even if a load happens in the same cycle. The dropped push sets `sts_ovf`, which stays set until `ovf_clr` is high at an edge with no dropped push. A dropped push in the same cycle as `ovf_clr` takes priority.
- R3: The `ld_stop2`, `ld_par_en` and `ld_par_even` outputs of a loaded character equal the `cfg_stop2`, `cfg_par_en` and `cfg_par_even` values present when that character was pushed.
- R4: With `cfg_cts_gate` = 1, `ld_valid` is high only in cycles where `cts_in` = 1. A character already loaded is not affected, and only the next offer waits.
- R5: While `cfg_tx_halt` = 1, `ld_valid` stays low whatever the queue holds.
- R6: While `cfg_brk` = 1, `txd` is 0. Otherwise `txd` follows `ser_bit` in the same cycle.
- R7: `rts_out` (1 = asserted) is registered. After each edge it is 0 if `cfg_rts_off` was 1, or if `cfg_rts_lvl` was nonzero and `rx_fill` was at least `cfg_rts_lvl`. Otherwise it is 1.
- R8: `sts_tx_irq` is high when the level is at or below the selected threshold:
  - `cfg_irq_thr` = 0 selects a level of at most 1.
  - `cfg_irq_thr` = 1 selects a level of at most 4.
  - Codes 2 and 3 select a level of exactly 0.
- R9: `sts_all_sent` is high exactly when the queue is empty and `shifter_busy` is low. The serialiser raises `shifter_busy` in the cycle after a load. `sts_cts` mirrors `cts_in`.
- R10: During reset the queue is empty, `ld_valid` and `sts_ovf` are 0, `rts_out` is 0, and `sts_all_sent` is 1 while `shifter_busy` is low.
- R11: While an offer is pending (`ld_valid` high, `ld_ready` low), the next cycle either withdraws `ld_valid` or presents the same `ld_char`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Push strobe |
| wr_char | input | 8 | Character to push |
| cfg_stop2 | input | 1 | Two stop bits for pushed character |
| cfg_par_en | input | 1 | Parity enable for pushed character |
| cfg_par_even | input | 1 | Even parity for pushed character |
| cfg_brk | input | 1 | Force break on line |
| cfg_cts_gate | input | 1 | Gate new starts on CTS |
| cfg_rts_off | input | 1 | Software RTS deassert |
| cfg_tx_halt | input | 1 | Halt transmission |
| cfg_irq_thr | input | 2 | Transmit interrupt threshold code |
| cfg_rts_lvl | input | 4 | Receive fill level that drops RTS (0 = unused) |
| rx_fill | input | 5 | Receive queue fill level |
| ovf_clr | input | 1 | Clear sticky overflow flag |
| cts_in | input | 1 | CTS line, 1 = asserted |
| ld_valid | output | 1 | Character offered to serialiser |
| ld_ready | input | 1 | Serialiser accepts character |
| ld_char | output | 8 | Offered character |
| ld_stop2 | output | 1 | Offered stop-bit framing |
| ld_par_en | output | 1 | Offered parity enable |
| ld_par_even | output | 1 | Offered parity sense |
| shifter_busy | input | 1 | Serialiser is shifting |
| ser_bit | input | 1 | Serial bit from serialiser |
| txd | output | 1 | Serial output line |
| rts_out | output | 1 | RTS line, 1 = asserted |
| sts_all_sent | output | 1 | Queue and serialiser idle |
| sts_cts | output | 1 | CTS line state |
| sts_tx_irq | output | 1 | Transmit level at or below threshold |
| sts_ovf | output | 1 | Sticky push-overflow flag |
| fifo_level | output | 4 | Number of stored entries |

## Verification
Some rules are checked by the assertions on every cycle:
- The CTS and halt gates on `ld_valid`.
- The break override of `txd`.
- The software RTS override.
- A full queue not growing, and the overflow flag setting on a push into a full queue.
- A pending offer holding its character.
- "All sent" never coinciding with an offer.

Some behaviour needs the bench's reference queue, because no single-cycle property can show it:
- Order and framing of characters across many pushes and loads.
- Exact level and threshold status for each code.
- RTS tracking of the fill threshold.
- Clearing of the overflow flag.
- Draining of the queue once the gates reopen.

// File: rtl/txq_pkg.sv
package txq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } txq_state_t;

    typedef struct packed {
        logic stop2;
        logic par_en;
        logic par_even;
    } txq_frame_t;

    localparam int unsigned FRAME_W = $bits(txq_frame_t);

    localparam logic [1:0] THR_CODE_A = 2'd0;
    localparam logic [1:0] THR_CODE_B = 2'd1;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 11,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] level,
    output logic          push_ok,
    input  logic          ovf_clr,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic          full;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full      = (level == CW'(DEPTH));
    assign push_ok   = push && !full;
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            level <= level + CW'(push_ok) - CW'(pop);
            if (push && full) begin
                ovf <= 1'b1;
            end else if (ovf_clr) begin
                ovf <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/txq_seq.sv
module txq_seq
    import txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_data,
    input  logic last_one,
    input  logic push_ok,
    input  logic go,
    input  logic ld_ready,
    output logic ld_valid,
    output logic pop
);

    txq_state_t state;
    txq_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (have_data) begin
                    state_nx = go ? ST_OFFER : ST_HELD;
                end
            end
            ST_OFFER: begin
                if (pop) begin
                    state_nx = (last_one && !push_ok) ? ST_IDLE : ST_OFFER;
                end else if (!go) begin
                    state_nx = ST_HELD;
                end else if (!have_data) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_HELD: begin
                if (go) begin
                    state_nx = ST_OFFER;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_valid = (state == ST_OFFER) && go && have_data;
        pop      = ld_valid && ld_ready;
    end

endmodule

// File: rtl/txq_ctl.sv
module txq_ctl
    import txq_pkg::*;
#(
    parameter int unsigned LVL_W     = 4,
    parameter int unsigned FILL_W    = 5,
    parameter int unsigned RTS_W     = 4,
    parameter int unsigned IRQ_LVL_A = 1,
    parameter int unsigned IRQ_LVL_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level,
    input  logic [1:0]        irq_code,
    input  logic              rts_off,
    input  logic [RTS_W-1:0]  rts_lvl,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              brk,
    input  logic              ser_bit,
    input  logic              shifter_busy,
    output logic              tx_irq,
    output logic              rts_out,
    output logic              txd,
    output logic              all_sent
);

    logic fill_hit;

    assign fill_hit = (rts_lvl != '0) && (int'(rx_fill) >= int'(rts_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_out <= 1'b0;
        end else begin
            rts_out <= !rts_off && !fill_hit;
        end
    end

    always_comb begin
        unique case (irq_code)
            THR_CODE_A: tx_irq = int'(level) <= int'(IRQ_LVL_A);
            THR_CODE_B: tx_irq = int'(level) <= int'(IRQ_LVL_B);
            default:    tx_irq = (level == '0);
        endcase
        txd      = brk ? 1'b0 : ser_bit;
        all_sent = (level == '0) && !shifter_busy;
    end

endmodule

// File: rtl/uart_txq_flow.sv
module uart_txq_flow
    import txq_pkg::*;
#(
    parameter int unsigned CHAR_W     = 8,
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned FILL_W     = 5,
    parameter int unsigned RTS_W      = 4,
    parameter int unsigned IRQ_LVL_A  = 1,
    parameter int unsigned IRQ_LVL_B  = 4,
    localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              cfg_stop2,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_brk,
    input  logic              cfg_cts_gate,
    input  logic              cfg_rts_off,
    input  logic              cfg_tx_halt,
    input  logic [1:0]        cfg_irq_thr,
    input  logic [RTS_W-1:0]  cfg_rts_lvl,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              ovf_clr,
    input  logic              cts_in,
    output logic              ld_valid,
    input  logic              ld_ready,
    output logic [CHAR_W-1:0] ld_char,
    output logic              ld_stop2,
    output logic              ld_par_en,
    output logic              ld_par_even,
    input  logic              shifter_busy,
    input  logic              ser_bit,
    output logic              txd,
    output logic              rts_out,
    output logic              sts_all_sent,
    output logic              sts_cts,
    output logic              sts_tx_irq,
    output logic              sts_ovf,
    output logic [LVL_W-1:0]  fifo_level
);

    localparam int unsigned ENT_W = CHAR_W + FRAME_W;

    txq_frame_t       frame_in;
    txq_frame_t       frame_out;
    logic [ENT_W-1:0] head;
    logic             push_ok;
    logic             pop;
    logic             go;

    assign frame_in = '{stop2: cfg_stop2, par_en: cfg_par_en, par_even: cfg_par_even};
    assign go       = !cfg_tx_halt && (!cfg_cts_gate || cts_in);

    txq_store #(
        .DEPTH (FIFO_DEPTH),
        .W     (ENT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data ({frame_in, wr_char}),
        .pop       (pop),
        .head_data (head),
        .level     (fifo_level),
        .push_ok   (push_ok),
        .ovf_clr   (ovf_clr),
        .ovf       (sts_ovf)
    );

    txq_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_data (fifo_level != '0),
        .last_one  (fifo_level == LVL_W'(1)),
        .push_ok   (push_ok),
        .go        (go),
        .ld_ready  (ld_ready),
        .ld_valid  (ld_valid),
        .pop       (pop)
    );

    txq_ctl #(
        .LVL_W     (LVL_W),
        .FILL_W    (FILL_W),
        .RTS_W     (RTS_W),
        .IRQ_LVL_A (IRQ_LVL_A),
        .IRQ_LVL_B (IRQ_LVL_B)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .level        (fifo_level),
        .irq_code     (cfg_irq_thr),
        .rts_off      (cfg_rts_off),
        .rts_lvl      (cfg_rts_lvl),
        .rx_fill      (rx_fill),
        .brk          (cfg_brk),
        .ser_bit      (ser_bit),
        .shifter_busy (shifter_busy),
        .tx_irq       (sts_tx_irq),
        .rts_out      (rts_out),
        .txd          (txd),
        .all_sent     (sts_all_sent)
    );

    assign frame_out   = head[ENT_W-1 -: FRAME_W];
    assign ld_char     = head[CHAR_W-1:0];
    assign ld_stop2    = frame_out.stop2;
    assign ld_par_en   = frame_out.par_en;
    assign ld_par_even = frame_out.par_even;
    assign sts_cts     = cts_in;

endmodule

// File: rtl/uart_txq_flow_chk.sv
module uart_txq_flow_chk #(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              ld_valid,
    input logic              ld_ready,
    input logic [CHAR_W-1:0] ld_char,
    input logic              cfg_tx_halt,
    input logic              cfg_cts_gate,
    input logic              cts_in,
    input logic              cfg_brk,
    input logic              txd,
    input logic              cfg_rts_off,
    input logic              rts_out,
    input logic              sts_ovf,
    input logic              sts_all_sent,
    input logic [LVL_W-1:0]  fifo_level
);

    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= int'(DEPTH));

    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH)) && !(ld_valid && ld_ready) |=> fifo_level == LVL_W'(DEPTH));

    a_r2_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == LVL_W'(DEPTH)) && wr_en |=> sts_ovf);

    a_r4_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && cfg_cts_gate |-> cts_in);

    a_r5_halt: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !cfg_tx_halt);

    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_brk |-> !txd);

    a_r7_rts_soft_off: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rts_off |=> !rts_out);

    a_r9_sent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sts_all_sent |-> !ld_valid);

    a_r11_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !ld_ready |=> !ld_valid || $stable(ld_char));

endmodule

bind uart_txq_flow uart_txq_flow_chk #(
    .CHAR_W (CHAR_W),
    .DEPTH  (FIFO_DEPTH),
    .LVL_W  (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .ld_valid     (ld_valid),
    .ld_ready     (ld_ready),
    .ld_char      (ld_char),
    .cfg_tx_halt  (cfg_tx_halt),
    .cfg_cts_gate (cfg_cts_gate),
    .cts_in       (cts_in),
    .cfg_brk      (cfg_brk),
    .txd          (txd),
    .cfg_rts_off  (cfg_rts_off),
    .rts_out      (rts_out),
    .sts_ovf      (sts_ovf),
    .sts_all_sent (sts_all_sent),
    .fifo_level   (fifo_level)
);

// File: tb/uart_txq_flow_test.sv
`timescale 1ns/100ps
module uart_txq_flow_test;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_char = '0;
    logic       cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_even = 1'b0;
    logic       cfg_brk = 1'b0, cfg_cts_gate = 1'b0, cfg_rts_off = 1'b1, cfg_tx_halt = 1'b0;
    logic [1:0] cfg_irq_thr = '0;
    logic [3:0] cfg_rts_lvl = '0;
    logic [4:0] rx_fill = '0;
    logic       ovf_clr = 1'b0, cts_in = 1'b0, ld_ready = 1'b0;
    logic       shifter_busy = 1'b0, ser_bit = 1'b1;
    logic       ld_valid, ld_stop2, ld_par_en, ld_par_even;
    logic [7:0] ld_char;
    logic       txd, rts_out, sts_all_sent, sts_cts, sts_tx_irq, sts_ovf;
    logic [3:0] fifo_level;

    always #2.5 clk = ~clk;

    uart_txq_flow uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_char(wr_char),
        .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_brk(cfg_brk), .cfg_cts_gate(cfg_cts_gate), .cfg_rts_off(cfg_rts_off),
        .cfg_tx_halt(cfg_tx_halt), .cfg_irq_thr(cfg_irq_thr), .cfg_rts_lvl(cfg_rts_lvl),
        .rx_fill(rx_fill), .ovf_clr(ovf_clr), .cts_in(cts_in), .ld_valid(ld_valid),
        .ld_ready(ld_ready), .ld_char(ld_char), .ld_stop2(ld_stop2), .ld_par_en(ld_par_en),
        .ld_par_even(ld_par_even), .shifter_busy(shifter_busy), .ser_bit(ser_bit),
        .txd(txd), .rts_out(rts_out), .sts_all_sent(sts_all_sent), .sts_cts(sts_cts),
        .sts_tx_irq(sts_tx_irq), .sts_ovf(sts_ovf), .fifo_level(fifo_level)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [10:0] q[$];
    bit   m_ovf = 0;
    bit   exp_rts = 0;
    bit   acc_prev = 0;
    int   busy_cnt = 0;
    bit   offer_pend = 0;
    logic [7:0] offer_char = '0;

    // knobs: percentages, or modes (2 = random)
    int k_push = 50, k_halt = 2, k_gate = 0, k_rdy = 60, k_clr = 5, k_thr = 4;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_irq(input int lvl, input logic [1:0] code);
        case (code)
            2'd0:    return lvl <= 1;
            2'd1:    return lvl <= 4;
            default: return lvl == 0;
        endcase
    endfunction

    function automatic bit rts_model(input bit off, input logic [3:0] lvl, input logic [4:0] fill);
        return !off && !((lvl != 0) && (int'(fill) >= int'(lvl)));
    endfunction

    task automatic step();
        bit acc, full, go;
        @(negedge clk);
        if (acc_prev) begin
            shifter_busy = 1'b1;
            busy_cnt = 1 + int'($urandom % 5);
        end else if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) shifter_busy = 1'b0;
        end
        #1;
        chk("R1 level", int'(fifo_level), q.size());
        chk("R2 overflow flag", int'(sts_ovf), int'(m_ovf));
        chk("R8 tx irq", int'(sts_tx_irq), int'(exp_irq(q.size(), cfg_irq_thr)));
        chk("R9 all sent", int'(sts_all_sent), int'(q.size() == 0 && !shifter_busy));
        chk("R9 cts status", int'(sts_cts), int'(cts_in));
        chk("R7 rts", int'(rts_out), int'(exp_rts));
        chk("R6 txd", int'(txd), cfg_brk ? 0 : int'(ser_bit));
        if (offer_pend && ld_valid) chk("R11 offer stable", int'(ld_char), int'(offer_char));

        wr_en        = ($urandom % 100) < k_push;
        wr_char      = 8'($urandom);
        cfg_stop2    = 1'($urandom);
        cfg_par_en   = 1'($urandom);
        cfg_par_even = 1'($urandom);
        cfg_tx_halt  = (k_halt == 2) ? (($urandom % 8) == 0) : k_halt[0];
        cfg_cts_gate = (k_gate == 2) ? 1'($urandom) : k_gate[0];
        if (($urandom % 10) == 0) cts_in = ~cts_in;
        cfg_brk      = ($urandom % 10) == 0;
        ser_bit      = 1'($urandom);
        cfg_rts_off  = ($urandom % 5) == 0;
        cfg_rts_lvl  = 4'($urandom);
        rx_fill      = 5'($urandom % 17);
        ovf_clr      = ($urandom % 100) < k_clr;
        ld_ready     = !shifter_busy && (($urandom % 100) < k_rdy);
        cfg_irq_thr  = (k_thr < 4) ? 2'(k_thr) : 2'($urandom);
        #1;
        go = !cfg_tx_halt && (!cfg_cts_gate || cts_in);
        if (ld_valid) chk("R4/R5 offer only when gate open", int'(go), 1);
        acc  = ld_valid && ld_ready;
        full = (q.size() == DEPTH);
        if (acc) begin
            if (q.size() == 0) chk("R1 load from empty queue", 1, 0);
            else begin
                chk("R1 order", int'(ld_char), int'(q[0][7:0]));
                chk("R3 framing", int'({ld_stop2, ld_par_en, ld_par_even}), int'(q[0][10:8]));
                void'(q.pop_front());
            end
        end
        if (wr_en && full) m_ovf = 1;
        else if (ovf_clr) m_ovf = 0;
        if (wr_en && !full) q.push_back({cfg_stop2, cfg_par_en, cfg_par_even, wr_char});
        exp_rts    = rts_model(cfg_rts_off, cfg_rts_lvl, rx_fill);
        acc_prev   = acc;
        offer_pend = ld_valid && !ld_ready;
        offer_char = ld_char;
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset values
        chk("R10 reset level", int'(fifo_level), 0);
        chk("R10 reset ld_valid", int'(ld_valid), 0);
        chk("R10 reset ovf", int'(sts_ovf), 0);
        chk("R10 reset rts", int'(rts_out), 0);
        chk("R10 reset all sent", int'(sts_all_sent), 1);
        rst_n = 1'b1;
        exp_rts = rts_model(cfg_rts_off, cfg_rts_lvl, rx_fill);

        // R5 / R2 / R8: fill under halt for each threshold code, then drain
        for (int code = 0; code < 4; code++) begin
            k_thr = code; k_halt = 1; k_push = 100; k_clr = 0; k_gate = 0;
            repeat (12) step();
            chk("R2 full level", int'(fifo_level), DEPTH);
            chk("R2 overflow set", int'(sts_ovf), 1);
            chk("R5 halt holds offer", int'(ld_valid), 0);
            k_halt = 0; k_push = 0; k_rdy = 100; k_clr = 100;
            repeat (60) step();
            chk("R1 drained", int'(fifo_level), 0);
            chk("R2 overflow cleared", int'(sts_ovf), 0);
        end

        // R4: CTS gating with random CTS toggles
        k_thr = 4; k_halt = 0; k_gate = 1; k_push = 40; k_rdy = 70; k_clr = 5;
        repeat (1500) step();

        // mixed random traffic
        k_halt = 2; k_gate = 2; k_push = 55; k_rdy = 50;
        repeat (2500) step();

        // final drain with gates open
        k_halt = 0; k_gate = 0; k_push = 0; k_rdy = 100;
        repeat (80) step();
        chk("R1 final drain", int'(fifo_level), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired (R1 progress) act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule